// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control window of an audio codec. A word-addressed bus reaches sixteen direct 32-bit registers. Direct register 0 acts as a pointer. Its five low bits pick one of thirty-two byte-wide indirect registers, and direct register 1 is the data port for the register the pointer selects. Each indirect register follows its own access rule. Some are write-only, some are read-only, and one forces a constant pattern into every value written to it.

Software uses the block by writing the pointer and then reading or writing the data port. Direct register 4 holds a control value. Writing it with bit 0 set returns the whole block to its reset image in the same clock. The written value, cut to 7 bits, is still stored. Read data is registered. No interrupt source exists, so the interrupt line stays low.

Top module: `codec_regfile`

## Requirements
- R1: `bus_word` selects one of 16 direct registers. A write to any slot except 1, 2 and 4 stores all 32 bits, and a later read returns them unchanged.
- R2: The indirect index is bits [4:0] of direct register 0, and the upper bits of register 0 are ignored for selection. A read of slot 1 returns the selected indirect byte zero-extended to 32 bits. A write to slot 1 stores `bus_wdata[7:0]` in that indirect register.
- R3: Indirect register 3 is write-only and always reads as 0 through slot 1.
- R4: Indirect registers 11 and 25 are read-only and ignore writes. Register 11 reads 0x00 and register 25 reads 0xA0.
- R5: A write to indirect register 12 stores (data AND 0x40) OR 0x8A.
- R6: After `rst` is asserted, every direct register and `bus_rdata` read 0. Every indirect register reads 0, except register 12, which reads 0x8A, and register 25, which reads 0xA0.
- R7: Direct register 2 is read-only, ignores writes and reads 0.
- R8: A write to slot 4 with `bus_wdata[0]`=1 restores the R6 state of all registers. In the same clock it stores `bus_wdata` AND 0x7F into register 4. With bit 0 clear, the write only stores `bus_wdata` AND 0x7F into register 4.
- R9: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value in cycles without a read. A read and a write in the same cycle return the value held before the write.
- R10: `irq` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 4 | Word slot, equal to byte address bits [5:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held low |

## Verification
A stale or corrupted pointer is only seen when the data port is read. The read returns the wrong byte, or fails to apply a forced or zero rule, one clock after the read strobe. A soft reset that misses some registers stays hidden until each of those registers is read back. For that reason, every direct slot and several indirect registers are read after each kind of reset. A fault in the read register shows up as a changed `bus_rdata` in a cycle with no read, or as a post-write value returned on a simultaneous read and write.

// File: rtl/codec_rf_pkg.sv
`timescale 1ns/1ps
package codec_rf_pkg;

    localparam int DIR_COUNT = 16;
    localparam int IND_COUNT = 32;
    localparam int DATA_W    = 32;
    localparam int IND_W     = 8;
    localparam int SLOT_W    = $clog2(DIR_COUNT);
    localparam int IDX_W     = $clog2(IND_COUNT);

    // direct slots with special behaviour
    localparam int SLOT_INDEX = 0;
    localparam int SLOT_DATA  = 1;
    localparam int SLOT_RO    = 2;
    localparam int SLOT_CTRL  = 4;

    // indirect registers with special behaviour
    localparam int IND_WO     = 3;
    localparam int IND_RO_A   = 11;
    localparam int IND_FORCED = 12;
    localparam int IND_RO_B   = 25;

    localparam logic [IND_W-1:0]  CODEC_ID  = 8'h8A;
    localparam logic [IND_W-1:0]  CHIP_ID   = 8'hA0;
    localparam logic [IND_W-1:0]  KEEP_MASK = 8'h40;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_007F;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic [IND_W-1:0] ind_reset_value(input int idx);
        if (idx == IND_FORCED) return CODEC_ID;
        if (idx == IND_RO_B)   return CHIP_ID;
        return '0;
    endfunction

    function automatic logic [IND_W-1:0] ind_write_value(input int idx,
                                                         input logic [IND_W-1:0] d);
        if (idx == IND_FORCED) return (d & KEEP_MASK) | CODEC_ID;
        return d;
    endfunction

    function automatic logic ind_is_readonly(input int idx);
        return (idx == IND_RO_A) || (idx == IND_RO_B);
    endfunction

endpackage

// File: rtl/crf_direct_bank.sv
`timescale 1ns/1ps
module crf_direct_bank
    import codec_rf_pkg::*;
#(
    parameter int N = DIR_COUNT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_req_t                req,
    input  logic                    soft_rst,
    output logic [N-1:0][DATA_W-1:0] regs_q
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == SLOT_DATA || i == SLOT_RO) begin : g_none
            // data port has no storage here; slot 2 is read-only zero
            assign regs_q[i] = '0;
        end else if (i == SLOT_CTRL) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[i] <= '0;
                end else if (req.wr && req.slot == SLOT_W'(i)) begin
                    regs_q[i] <= req.data & CTRL_MASK;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    regs_q[i] <= '0;
                end else if (req.wr && req.slot == SLOT_W'(i)) begin
                    regs_q[i] <= req.data;
                end
            end
        end
    end

endmodule

// File: rtl/crf_indirect_bank.sv
`timescale 1ns/1ps
module crf_indirect_bank
    import codec_rf_pkg::*;
#(
    parameter int N = IND_COUNT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       idx,
    input  logic [IND_W-1:0]       wdata,
    output logic [N-1:0][IND_W-1:0] regs_q
);

    for (genvar i = 0; i < N; i++) begin : g_ind
        if (ind_is_readonly(i)) begin : g_const
            assign regs_q[i] = ind_reset_value(i);
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    regs_q[i] <= ind_reset_value(i);
                end else if (wr_en && idx == IDX_W'(i)) begin
                    regs_q[i] <= ind_write_value(i, wdata);
                end
            end
        end
    end

endmodule

// File: rtl/crf_read_port.sv
`timescale 1ns/1ps
module crf_read_port
    import codec_rf_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  bus_req_t                        req,
    input  logic [IDX_W-1:0]                idx,
    input  logic [DIR_COUNT-1:0][DATA_W-1:0] dir_q,
    input  logic [IND_COUNT-1:0][IND_W-1:0] ind_q,
    output logic [DATA_W-1:0]               rdata
);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        if (req.slot == SLOT_W'(SLOT_DATA)) begin
            if (idx == IDX_W'(IND_WO)) rd_next = '0;
            else                       rd_next = DATA_W'(ind_q[idx]);
        end else begin
            rd_next = dir_q[req.slot];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_next;
    end

endmodule

// File: rtl/codec_regfile.sv
`timescale 1ns/1ps
module codec_regfile
    import codec_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SLOT_W-1:0] bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    bus_req_t                         req;
    logic                             soft_rst;
    logic                             ind_wr;
    logic [IDX_W-1:0]                 index_q;
    logic [DIR_COUNT-1:0][DATA_W-1:0] dir_q;
    logic [IND_COUNT-1:0][IND_W-1:0]  ind_q;

    assign req      = '{wr: bus_wr, rd: bus_rd, slot: bus_word, data: bus_wdata};
    assign soft_rst = bus_wr && bus_word == SLOT_W'(SLOT_CTRL) && bus_wdata[0];
    assign ind_wr   = bus_wr && bus_word == SLOT_W'(SLOT_DATA);
    assign index_q  = dir_q[SLOT_INDEX][IDX_W-1:0];
    assign irq      = 1'b0;

    crf_direct_bank #(.N(DIR_COUNT)) i_direct (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .soft_rst (soft_rst),
        .regs_q   (dir_q)
    );

    crf_indirect_bank #(.N(IND_COUNT)) i_indirect (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (ind_wr),
        .idx      (index_q),
        .wdata    (bus_wdata[IND_W-1:0]),
        .regs_q   (ind_q)
    );

    crf_read_port i_read (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .idx   (index_q),
        .dir_q (dir_q),
        .ind_q (ind_q),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/crf_checker.sv
`timescale 1ns/1ps
module crf_checker
    import codec_rf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [SLOT_W-1:0] bus_word,
    input logic              ctrl_bit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [IDX_W-1:0]  index_q
);

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq == 1'b0); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R9

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 4'd1 && index_q == 5'd3) |=> bus_rdata == '0); // R3

    AST_RO_CHIP_ID: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 4'd1 && index_q == 5'd25) |=> bus_rdata == 32'hA0); // R4

    AST_RO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 4'd1 && index_q == 5'd11) |=> bus_rdata == '0); // R4

    AST_FORCED_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 4'd1 && index_q == 5'd12)
            |=> (bus_rdata & ~32'h40) == 32'h8A); // R5

    AST_SLOT2_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 4'd2) |=> bus_rdata == '0); // R7

    AST_SOFT_CLEARS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 4'd4 && ctrl_bit) |=> index_q == '0); // R8

endmodule

bind codec_regfile crf_checker i_crf_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_word  (bus_word),
    .ctrl_bit  (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .index_q   (index_q)
);

// File: tb/test_codec_regfile.sv
`timescale 1ns/1ps
module test_codec_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    codec_regfile i_codec_regfile (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic [31:0] d);
        @(negedge clk);
        bus_word = 4'(s); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_word = 4'(s); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata, exp, tag);
    endtask

    task automatic ind_chk(input int idx, input logic [31:0] exp, input string tag);
        wr(0, 32'(idx));
        rd_chk(1, exp, tag);
    endtask

    task automatic t_reset_image(input string tag);
        check(bus_rdata, 32'h0, {tag, " rdata"});
        for (int s = 0; s < 16; s++) begin
            if (s != 1) rd_chk(s, 32'h0, {tag, " direct"});
        end
        ind_chk(0, 32'h00, {tag, " ind0"});
        ind_chk(7, 32'h00, {tag, " ind7"});
        ind_chk(12, 32'h8A, {tag, " ind12"});
        ind_chk(25, 32'hA0, {tag, " ind25"});
        ind_chk(31, 32'h00, {tag, " ind31"});
    endtask

    task automatic t_direct;
        wr(5, 32'hDEAD_BEEF);
        wr(15, 32'h1234_5678);
        wr(0, 32'hFFFF_FFE7);
        rd_chk(5, 32'hDEAD_BEEF, "R1 slot5");
        rd_chk(15, 32'h1234_5678, "R1 slot15");
        rd_chk(0, 32'hFFFF_FFE7, "R1 slot0 full width");
        wr(2, 32'hCAFE_F00D);
        rd_chk(2, 32'h0, "R7 slot2 read-only");
    endtask

    task automatic t_indirect;
        wr(0, 32'hFFFF_FFE7);           // index 7, upper bits set
        wr(1, 32'hFFFF_FF5A);
        rd_chk(1, 32'h5A, "R2 ind7 via wide pointer");
        ind_chk(3, 32'h0, "R3 ind3 before write");
        wr(1, 32'h77);
        rd_chk(1, 32'h0, "R3 ind3 write-only");
        wr(0, 11); wr(1, 32'h33);
        rd_chk(1, 32'h0, "R4 ind11 ignores write");
        wr(0, 25); wr(1, 32'h00);
        rd_chk(1, 32'hA0, "R4 ind25 ignores write");
        wr(0, 12); wr(1, 32'hFF);
        rd_chk(1, 32'hCA, "R5 ind12 all ones");
        wr(1, 32'h00);
        rd_chk(1, 32'h8A, "R5 ind12 zero");
        wr(0, 31); wr(1, 32'h81);
        rd_chk(1, 32'h81, "R2 ind31");
        ind_chk(7, 32'h5A, "R2 ind7 retained");
    endtask

    task automatic t_soft_reset;
        wr(6, 32'h0000_00AA);
        wr(0, 12); wr(1, 32'h40);
        wr(4, 32'h8000_0002);           // bit0 clear
        rd_chk(4, 32'h02, "R8 ctrl masked no reset");
        rd_chk(6, 32'hAA, "R8 no reset keeps slot6");
        rd_chk(1, 32'hCA, "R8 no reset keeps ind12");
        wr(4, 32'hFFFF_FFFF);           // bit0 set
        rd_chk(4, 32'h7F, "R8 ctrl stored after reset");
        rd_chk(1, 32'h00, "R8 index cleared reads ind0");
        rd_chk(6, 32'h0, "R8 slot6 cleared");
        rd_chk(5, 32'h0, "R8 slot5 cleared");
        ind_chk(7, 32'h0, "R8 ind7 cleared");
        ind_chk(12, 32'h8A, "R8 ind12 codec id");
        ind_chk(25, 32'hA0, "R8 ind25 chip id");
    endtask

    task automatic t_read_timing;
        wr(8, 32'h1);
        @(negedge clk);
        bus_word = 4'd8; bus_wdata = 32'h2; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(bus_rdata, 32'h1, "R9 read with write returns old");
        rd_chk(8, 32'h2, "R9 new value after");
        wr(9, 32'h55);
        repeat (3) @(negedge clk);
        check(bus_rdata, 32'h2, "R9 rdata holds without read");
        check({31'h0, irq}, 32'h0, "R10 irq low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({31'h0, irq}, 32'h0, "R10 irq low at start");
        t_reset_image("R6 power-up");
        t_direct;
        t_indirect;
        t_soft_reset;
        t_read_timing;
        wr(5, 32'h1111_2222); wr(0, 12); wr(1, 32'h40); rd_chk(5, 32'h1111_2222, "R1 pre hw reset");
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        t_reset_image("R6 hw reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule